// File: doc/BRIEF.md
# Pad Delay Configuration Word Calculator

This block turns a requested pad timing into the single configuration word that a programmable delay line expects. A request carries four unsigned operands in picoseconds. Two are the delays wanted on the analog path and on the gate path. The other two are the delays of one coarse element and of one fine element, as measured by calibration elsewhere on the chip.

The gate path always uses fixed element sizes of 920 ps (coarse) and 60 ps (fine). The analog path uses the measured sizes. Each path is split into a coarse count and a scaled fine term. The parts are summed. If the fine count grows too large, the total is rebuilt in picoseconds and split again. The counts are then packed into the register encoding.

Each request is taken through a valid/ready handshake while the block is idle. Every division, including the division by a constant, runs through one shared restoring divider, one quotient bit per clock cycle. For this reason the answer always appears a fixed number of cycles after acceptance. A zero element delay gives an error flag and a zero word, never an undefined result.

Top module: `pad_delay_word_calc`

## Requirements
- R1: The gate coarse count is gate_ps / 920. The gate fine term is ((gate_ps mod 920) * 10) / 60.
- R2: The analog coarse count is analog_ps / coarse_ps. The analog fine term is ((analog_ps mod coarse_ps) * 10) / fine_ps.
- R3: The summed coarse count is the sum of both coarse counts. The summed fine count is (gate fine term + analog fine term) / 10.
- R4: If the summed fine count is above 22, the block forms total = coarse*coarse_ps + fine*fine_ps. The coarse count then becomes total / coarse_ps and the fine count becomes (total mod coarse_ps) / fine_ps. A fine count of exactly 22 is left unchanged.
- R5: rsp_word = (0x29400 XOR (coarse << 5)) + fine. Every product, sum and shift is taken modulo 2^32, and every division truncates.
- R6: If coarse_ps or fine_ps is 0, the response has rsp_err = 1 and rsp_word = 0. Otherwise rsp_err = 0.
- R7: req_ready is 1 only while the block is idle. A request is accepted on a clock edge where req_valid and req_ready are both 1. While the block is busy, req_valid and the operand inputs have no effect on the pending result.
- R8: rsp_valid is 1 for exactly one cycle, 231 clock edges after the accepting edge (7 divisions of 33 cycles each). req_ready returns to 1 in the same cycle.
- R9: After reset, req_ready = 1, rsp_valid = 0, rsp_word = 0 and rsp_err = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_analog_ps | input | 32 | Requested analog-path delay |
| req_gate_ps | input | 32 | Requested gate-path delay |
| req_coarse_ps | input | 32 | Measured coarse element delay |
| req_fine_ps | input | 32 | Measured fine element delay |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_word | output | 32 | Packed configuration word |
| rsp_err | output | 1 | A zero element delay was given |

## Verification
A faulty divider step or a wrong capture in the sequencer spoils one quotient or remainder. Each later stage depends on that value, so the fault shows up at the single result strobe as a wrong word. It is always seen exactly 231 cycles after acceptance.

A fault in the stage counter or the state sequence moves the strobe away from that cycle, or makes req_ready reappear at the wrong time. Either one is caught on the first request. Faults in the renormalisation choice only show when the summed fine count crosses 22. The bench therefore drives the values on both sides of that boundary.

// File: rtl/pdw_pkg.sv
package pdw_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_GATE_CRS,
      PH_GATE_FIN,
      PH_ANA_CRS,
      PH_ANA_FIN,
      PH_FINE_SUM,
      PH_RENORM_CRS,
      PH_RENORM_FIN
   } pdw_phase_e;

   localparam int unsigned PDW_DIVS = 7;

endpackage

// File: rtl/pdw_restoring_div.sv
module pdw_restoring_div #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   output logic [W-1:0] quotient,
   output logic [W-1:0] remainder,
   output logic         done
);
   localparam int unsigned CW = $clog2(W + 1);

   logic [W-1:0]  rem_q, quo_q, dvs_q, dvd_q;
   logic [CW-1:0] cnt_q;
   logic          done_q;
   logic [W:0]    part, diff;
   logic          fits;

   always_comb begin
      part = {rem_q, quo_q[W-1]};
      diff = part - {1'b0, dvs_q};
      fits = part >= {1'b0, dvs_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         quo_q  <= '0;
         dvs_q  <= '0;
         dvd_q  <= '0;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start) begin
            rem_q <= '0;
            quo_q <= dividend;
            dvs_q <= divisor;
            dvd_q <= dividend;
            cnt_q <= CW'(W);
         end else if (cnt_q != '0) begin
            rem_q <= fits ? diff[W-1:0] : part[W-1:0];
            quo_q <= {quo_q[W-2:0], fits};
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) done_q <= 1'b1;
         end
      end
   end

   assign quotient  = quo_q;
   assign remainder = rem_q;
   assign done      = done_q;

   // R5
   div_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && dvs_q != '0) |-> (quo_q * dvs_q + rem_q == dvd_q));

   // R5
   div_rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && dvs_q != '0) |-> (rem_q < dvs_q));

endmodule

// File: rtl/pdw_packer.sv
module pdw_packer #(
   parameter int unsigned W           = 32,
   parameter int unsigned FINE_LIMIT  = 22,
   parameter int unsigned CRS_SHIFT   = 5,
   parameter logic [W-1:0] BASE_WORD  = W'(32'h29400)
) (
   input  logic [W-1:0] crs_sum,
   input  logic [W-1:0] fin_sum,
   input  logic [W-1:0] crs_ren,
   input  logic [W-1:0] fin_ren,
   input  logic         bad_div,
   output logic [W-1:0] word
);
   logic         spill;
   logic [W-1:0] crs_sel, fin_sel;

   always_comb begin
      spill   = fin_sum > W'(FINE_LIMIT);
      crs_sel = spill ? crs_ren : crs_sum;
      fin_sel = spill ? fin_ren : fin_sum;
      word    = bad_div ? '0 : ((BASE_WORD ^ (crs_sel << CRS_SHIFT)) + fin_sel);
   end

endmodule

// File: rtl/pad_delay_word_calc.sv
module pad_delay_word_calc
   import pdw_pkg::*;
#(
   parameter int unsigned  W            = 32,
   parameter int unsigned  GATE_CRS_PS  = 920,
   parameter int unsigned  GATE_FIN_PS  = 60,
   parameter int unsigned  FINE_SCALE   = 10,
   parameter int unsigned  FINE_LIMIT   = 22,
   parameter int unsigned  CRS_SHIFT    = 5,
   parameter logic [W-1:0] BASE_WORD    = W'(32'h29400)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         req_valid,
   output logic         req_ready,
   input  logic [W-1:0] req_analog_ps,
   input  logic [W-1:0] req_gate_ps,
   input  logic [W-1:0] req_coarse_ps,
   input  logic [W-1:0] req_fine_ps,
   output logic         rsp_valid,
   output logic [W-1:0] rsp_word,
   output logic         rsp_err
);
   localparam int unsigned  LAT   = PDW_DIVS * (W + 1);
   localparam logic [W-1:0] SCALE = W'(FINE_SCALE);

   generate
      if (W < 18) begin : g_width_bad
         $error("pad_delay_word_calc: W must hold the base word");
      end
      if (GATE_CRS_PS == 0 || GATE_FIN_PS == 0 || FINE_SCALE == 0) begin : g_const_bad
         $error("pad_delay_word_calc: fixed divisors must be nonzero");
      end
   endgenerate

   pdw_phase_e   ph_q;
   logic [W-1:0] ana_q, crsd_q, find_q;
   logic [W-1:0] crs_q, gfin_q, fin_q, rcrs_q;
   logic         err_q, accept;
   logic         rsp_valid_q, rsp_err_q;
   logic [W-1:0] rsp_word_q;

   logic         dv_start, dv_done;
   logic [W-1:0] dv_num, dv_den, dv_quo, dv_rem;
   logic [W-1:0] total, pk_word;

   assign req_ready = (ph_q == PH_IDLE);
   assign accept    = req_valid && req_ready;
   assign total     = crs_q * crsd_q + dv_quo * find_q;

   always_comb begin
      dv_start = dv_done && (ph_q != PH_RENORM_FIN) && (ph_q != PH_IDLE);
      dv_num   = '0;
      dv_den   = '0;
      unique case (ph_q)
         PH_IDLE: begin
            dv_start = accept;
            dv_num   = req_gate_ps;
            dv_den   = W'(GATE_CRS_PS);
         end
         PH_GATE_CRS:   begin dv_num = dv_rem * SCALE;   dv_den = W'(GATE_FIN_PS); end
         PH_GATE_FIN:   begin dv_num = ana_q;            dv_den = crsd_q;          end
         PH_ANA_CRS:    begin dv_num = dv_rem * SCALE;   dv_den = find_q;          end
         PH_ANA_FIN:    begin dv_num = gfin_q + dv_quo;  dv_den = SCALE;           end
         PH_FINE_SUM:   begin dv_num = total;            dv_den = crsd_q;          end
         PH_RENORM_CRS: begin dv_num = dv_rem;           dv_den = find_q;          end
         default:       begin dv_num = '0;               dv_den = '0;              end
      endcase
   end

   pdw_restoring_div #(.W(W)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (dv_start),
      .dividend  (dv_num),
      .divisor   (dv_den),
      .quotient  (dv_quo),
      .remainder (dv_rem),
      .done      (dv_done)
   );

   pdw_packer #(
      .W          (W),
      .FINE_LIMIT (FINE_LIMIT),
      .CRS_SHIFT  (CRS_SHIFT),
      .BASE_WORD  (BASE_WORD)
   ) u_pack (
      .crs_sum (crs_q),
      .fin_sum (fin_q),
      .crs_ren (rcrs_q),
      .fin_ren (dv_quo),
      .bad_div (err_q),
      .word    (pk_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q        <= PH_IDLE;
         ana_q       <= '0;
         crsd_q      <= '0;
         find_q      <= '0;
         crs_q       <= '0;
         gfin_q      <= '0;
         fin_q       <= '0;
         rcrs_q      <= '0;
         err_q       <= 1'b0;
         rsp_valid_q <= 1'b0;
         rsp_word_q  <= '0;
         rsp_err_q   <= 1'b0;
      end else begin
         rsp_valid_q <= 1'b0;
         if (ph_q == PH_IDLE) begin
            if (accept) begin
               ana_q  <= req_analog_ps;
               crsd_q <= req_coarse_ps;
               find_q <= req_fine_ps;
               err_q  <= (req_coarse_ps == '0) || (req_fine_ps == '0);
               ph_q   <= PH_GATE_CRS;
            end
         end else if (dv_done) begin
            unique case (ph_q)
               PH_GATE_CRS:   begin crs_q  <= dv_quo;         ph_q <= PH_GATE_FIN;   end
               PH_GATE_FIN:   begin gfin_q <= dv_quo;         ph_q <= PH_ANA_CRS;    end
               PH_ANA_CRS:    begin crs_q  <= crs_q + dv_quo; ph_q <= PH_ANA_FIN;    end
               PH_ANA_FIN:    begin                           ph_q <= PH_FINE_SUM;   end
               PH_FINE_SUM:   begin fin_q  <= dv_quo;         ph_q <= PH_RENORM_CRS; end
               PH_RENORM_CRS: begin rcrs_q <= dv_quo;         ph_q <= PH_RENORM_FIN; end
               default: begin
                  rsp_valid_q <= 1'b1;
                  rsp_word_q  <= pk_word;
                  rsp_err_q   <= err_q;
                  ph_q        <= PH_IDLE;
               end
            endcase
         end
      end
   end

   assign rsp_valid = rsp_valid_q;
   assign rsp_word  = rsp_word_q;
   assign rsp_err   = rsp_err_q;

   logic [15:0] lat_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          lat_q <= '0;
      else if (accept)     lat_q <= '0;
      else if (!req_ready) lat_q <= lat_q + 1'b1;
   end

   // R8
   rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (lat_q == 16'(LAT)));

   // R8
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R7
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_ready);

   // R6
   err_zero_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> (rsp_word == '0));

   // R8
   ready_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> req_ready);

endmodule

// File: tb/pad_delay_word_calc_test.sv
module pad_delay_word_calc_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_analog_ps = '0, req_gate_ps = '0, req_coarse_ps = '0, req_fine_ps = '0;
   logic        rsp_valid;
   logic [31:0] rsp_word;
   logic        rsp_err;

   int unsigned n_cmp = 0;
   int unsigned n_bad = 0;

   always #2 clk = ~clk;

   pad_delay_word_calc uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_analog_ps (req_analog_ps),
      .req_gate_ps   (req_gate_ps),
      .req_coarse_ps (req_coarse_ps),
      .req_fine_ps   (req_fine_ps),
      .rsp_valid     (rsp_valid),
      .rsp_word      (rsp_word),
      .rsp_err       (rsp_err)
   );

   function automatic logic [31:0] model_word(input logic [31:0] a, g, cd, fd);
      logic [31:0] gc, gf, ac, af, c, f, t;
      if (cd == 0 || fd == 0) return 32'd0;
      gc = g / 32'd920;
      gf = ((g % 32'd920) * 32'd10) / 32'd60;
      ac = a / cd;
      af = ((a % cd) * 32'd10) / fd;
      c  = gc + ac;
      f  = (gf + af) / 32'd10;
      if (f > 32'd22) begin
         t = c * cd + f * fd;
         c = t / cd;
         f = (t % cd) / fd;
      end
      return (32'h29400 ^ (c << 5)) + f;
   endfunction

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic run_op(input string req, input logic [31:0] a, g, cd, fd, input bit garble);
      logic [31:0] exp_w;
      int cyc;
      exp_w = model_word(a, g, cd, fd);
      @(negedge clk);
      req_analog_ps = a; req_gate_ps = g; req_coarse_ps = cd; req_fine_ps = fd;
      req_valid = 1'b1;
      check("R9 idle ready before request", 32'(req_ready), 32'd1);
      @(posedge clk);
      @(negedge clk);
      if (garble) begin
         req_analog_ps = $urandom; req_gate_ps = $urandom;
         req_coarse_ps = 32'd0;    req_fine_ps = $urandom;
      end else begin
         req_valid = 1'b0;
      end
      check("R7 busy after accept", 32'(req_ready), 32'd0);
      cyc = 0;
      while (!rsp_valid && cyc < 1000) begin
         @(posedge clk);
         @(negedge clk);
         cyc++;
      end
      req_valid = 1'b0;
      check({req, " R8 latency"}, 32'(cyc), 32'd231);
      check({req, " word"}, rsp_word, exp_w);
      check({req, " R6 err flag"}, 32'(rsp_err), 32'((cd == 0) || (fd == 0)));
      check("R8 ready with response", 32'(req_ready), 32'd1);
      @(negedge clk);
      check("R8 single pulse", 32'(rsp_valid), 32'd0);
   endtask

   initial begin
      #(200000 * 4);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd7321));
      #1;
      @(negedge clk);
      // R9 reset state
      check("R9 ready", 32'(req_ready), 32'd1);
      check("R9 valid", 32'(rsp_valid), 32'd0);
      check("R9 word", rsp_word, 32'd0);
      check("R9 err", 32'(rsp_err), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      run_op("R1 gate only",        32'd0,    32'd5000,  32'd300,  32'd10, 1'b0);
      run_op("R1 gate remainder",   32'd0,    32'd919,   32'd1,    32'd1,  1'b0);
      run_op("R2 analog only",      32'd1234, 32'd0,     32'd300,  32'd7,  1'b0);
      run_op("R3 both paths",       32'd2500, 32'd3000,  32'd400,  32'd45, 1'b0);
      run_op("R4 fine exactly 22",  32'd220,  32'd0,     32'd1000, 32'd10, 1'b0);
      run_op("R4 fine 23 renorm",   32'd230,  32'd0,     32'd1000, 32'd10, 1'b0);
      run_op("R4 large renorm",     32'd999,  32'd1839,  32'd1000, 32'd5,  1'b0);
      run_op("R5 wrapping values",  32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd1, 32'd1, 1'b0);
      run_op("R6 zero coarse",      32'd500,  32'd900,   32'd0,    32'd10, 1'b0);
      run_op("R6 zero fine",        32'd500,  32'd900,   32'd300,  32'd0,  1'b0);
      run_op("R7 inputs ignored",   32'd777,  32'd4321,  32'd350,  32'd12, 1'b1);

      for (int i = 0; i < 140; i++) begin
         logic [31:0] a, g, cd, fd;
         if (i % 10 == 9) begin
            a = $urandom; g = $urandom; cd = $urandom; fd = $urandom % 32'd300;
         end else begin
            a  = $urandom % 32'd200000;
            g  = $urandom % 32'd200000;
            cd = 32'd1 + ($urandom % 32'd4000);
            fd = 32'd1 + ($urandom % 32'd80);
         end
         run_op("R5 random", a, g, cd, fd, (i % 7) == 3);
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule